// File: doc/BRIEF.md
# Quarter-Second Interval Watchdog

This block is a watchdog for a small controller. A prescaler turns the system clock into a tick every `TICK_CLKS` clocks. That tick is the quarter-second time base. A second counter counts ticks. Software programs the block through one write-only control byte, qualified by a write strobe. The byte carries a run bit, a restart strobe bit and a 3-bit interval code. If software lets the count reach the selected number of ticks, the block raises a reset request for one clock and starts counting again.

Interval code N selects N ticks. Code 0 selects the longest period, eight ticks. Software changes the interval by rewriting the code, and the count is not restarted. Clearing the run bit freezes the watchdog at zero.

Top module: `qtr_watchdog`

## Requirements
- R1: After reset the watchdog is stopped. `rst_req` is 0 and stays 0 until a control write sets the run bit.
- R2: The control byte is taken from `cfg_wdata` on a clock edge where `cfg_we` is 1. Its fields are:
  - bit 7: run
  - bit 6: restart strobe
  - bits 2:0: interval code

  A write that turns the run bit on starts the tick count and the prescaler from zero.
- R3: For interval codes 1 to 7, `rst_req` goes high in the cycle that follows the clock edge lying code×`TICK_CLKS` clocks after the starting write edge.
- R4: Interval code 0 gives a period of 8×`TICK_CLKS` clocks.
- R5: `rst_req` is high for exactly one clock per overflow. The count then restarts from zero, so overflows repeat at the programmed period while running.
- R6: While the run bit is 0, no reset request is raised, and the prescaler and the tick count are held at zero. A later enabling write therefore waits a full interval.
- R7: A write with the restart bit set zeroes the prescaler and the tick count on that write edge. The next overflow comes a full interval after that edge.
- R8: A write with the restart bit at 0 and the run bit already on leaves the count running. The next overflow keeps its original timing.
- R9: A new interval code takes effect at the next tick comparison, and the count is not restarted. If the ticks already counted plus that tick reach the new code's length, the overflow happens on that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte (bit 7 run, bit 6 restart, bits 2:0 interval code) |
| rst_req | output | 1 | One-clock reset request on overflow |

## Verification
The bench sweeps every interval code across several periods.
- It checks that code 0 lands at eight ticks. A design that decoded code 0 literally would fire every tick or never fire.
- It shrinks the interval below the ticks already counted. A design with an equality compare would run past the point and miss the overflow for a long time.
- It lengthens the interval mid-count. A design that restarted on every write would fire late.
- It sends a write with the restart bit at 0. A design that treated any write as a restart would shift the overflow.
- It disables the watchdog and enables it again. A design that only paused the count would fire early.
- It watches every cycle around each overflow. A stretched pulse, or a count that does not return to zero after an overflow, shows up as a mismatch.

// File: rtl/qwd_pkg.sv
package qwd_pkg;

    localparam int CODE_W  = 3;
    localparam int UNIT_W  = 4;
    localparam int DATA_W  = 8;
    localparam int RUN_BIT = 7;
    localparam int RST_BIT = 6;
    localparam int CODE_LO = 0;

    typedef struct packed {
        logic              run;
        logic [CODE_W-1:0] code;
    } qwd_cfg_t;

    // Interval length in ticks: code N gives N, code 0 gives the longest (8).
    function automatic logic [UNIT_W-1:0] code_to_units(input logic [CODE_W-1:0] c);
        logic [UNIT_W-1:0] r;
        if (c == '0) begin
            r = UNIT_W'(8);
        end else begin
            r = UNIT_W'(c);
        end
        return r;
    endfunction

endpackage

// File: rtl/qwd_cfg_reg.sv
module qwd_cfg_reg
    import qwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output qwd_cfg_t          cfg,
    output logic              restart
);

    qwd_cfg_t cfg_q;
    logic     unused_bits;

    assign unused_bits = ^wdata[DATA_W-3:CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.run  <= wdata[RUN_BIT];
            cfg_q.code <= wdata[CODE_LO +: CODE_W];
        end
    end

    // Restart acts in the same edge as the write; it is never stored.
    assign restart = we & wdata[RST_BIT];
    assign cfg     = cfg_q;

endmodule

// File: rtl/qwd_tick_gen.sv
module qwd_tick_gen #(
    parameter int TICK_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

    generate
        if (TICK_CLKS == 1) begin : g_direct
            assign tick = run & ~restart;
        end else begin : g_count
            logic [PW-1:0] pre_q;
            logic          last;

            assign last = (pre_q == PW'(TICK_CLKS - 1));
            assign tick = run & ~restart & last;

            always_ff @(posedge clk) begin
                if (rst || !run || restart) begin
                    pre_q <= '0;
                end else if (last) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/qwd_unit_cnt.sv
module qwd_unit_cnt
    import qwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic [UNIT_W-1:0] units,
    output logic              overflow
);

    logic [UNIT_W-1:0] limit;
    logic [UNIT_W-1:0] nxt;
    logic [UNIT_W-1:0] units_q;
    logic              ovf_q;

    assign limit = code_to_units(code);
    assign nxt   = units_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            units_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (tick) begin
                // Greater-or-equal covers a code shortened below the count.
                if (nxt >= limit) begin
                    units_q <= '0;
                    ovf_q   <= 1'b1;
                end else begin
                    units_q <= nxt;
                end
            end
        end
    end

    assign units    = units_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/qtr_watchdog.sv
module qtr_watchdog
    import qwd_pkg::*;
#(
    parameter int TICK_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              rst_req
);

    qwd_cfg_t          cfg_w;
    logic              clr_w;
    logic              tick_w;
    logic              en_w;
    logic [UNIT_W-1:0] units_w;

    qwd_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg     (cfg_w),
        .restart (clr_w)
    );

    assign en_w = cfg_w.run;

    qwd_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (en_w),
        .restart (clr_w),
        .tick    (tick_w)
    );

    qwd_unit_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (en_w),
        .restart  (clr_w),
        .tick     (tick_w),
        .code     (cfg_w.code),
        .units    (units_w),
        .overflow (rst_req)
    );

endmodule

// File: rtl/qwd_checker.sv
module qwd_checker
    import qwd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              tick,
    input logic              clr,
    input logic              en,
    input logic [UNIT_W-1:0] units
);

    p_pulse_one_r5: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    p_zero_after_req_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> (units == '0));

    p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!req && units == '0));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!req && units == '0));

    p_req_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(tick));

endmodule

bind qtr_watchdog qwd_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .req   (rst_req),
    .tick  (tick_w),
    .clr   (clr_w),
    .en    (en_w),
    .units (units_w)
);

// File: tb/qtr_watchdog_tb.sv
module qtr_watchdog_tb;

    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    qtr_watchdog #(.TICK_CLKS(T)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rst_req   (rst_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_req=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Entered and left at a negedge; the write lands on the posedge between.
    task automatic wr(input bit run, input bit clr, input logic [2:0] code);
        cfg_wdata = {run, clr, 3'b000, code};
        cfg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    // Cycle k (1..n) after the last write; expect a pulse at first, first+per, ...
    task automatic watch(input string req, input int n, input int first, input int per);
        for (int k = 1; k <= n; k++) begin
            bit hit;
            @(posedge clk);
            @(negedge clk);
            hit = (first != 0) && (k >= first) &&
                  ((per == 0) ? (k == first) : (((k - first) % per) == 0));
            check(req, rst_req, hit);
        end
    endtask

    task automatic t_reset();
        check("R1", rst_req, 1'b0);
        watch("R1", 60, 0, 0);
    endtask

    task automatic t_codes();
        for (int c = 1; c < 8; c++) begin
            wr(1'b1, 1'b1, 3'(c));
            watch("R3", 3 * c * T, c * T, c * T);
        end
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_code0();
        wr(1'b1, 1'b1, 3'd0);
        watch("R4", 2 * 8 * T + 3, 8 * T, 8 * T);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_disable();
        wr(1'b1, 1'b1, 3'd2);
        watch("R6", 5, 0, 0);
        wr(1'b0, 1'b0, 3'd2);
        watch("R6", 40, 0, 0);
        wr(1'b1, 1'b0, 3'd2);
        watch("R6", 2 * T + 1, 2 * T, 0);
        wr(1'b0, 1'b0, 3'd2);
    endtask

    task automatic t_clear();
        wr(1'b1, 1'b1, 3'd3);
        watch("R7", 7, 0, 0);
        wr(1'b1, 1'b1, 3'd3);
        watch("R7", 3 * T + 2, 3 * T, 0);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_noclear();
        wr(1'b1, 1'b1, 3'd3);
        watch("R8", 5, 0, 0);
        wr(1'b1, 1'b0, 3'd3);
        watch("R8", 10, 6, 0);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_shrink();
        wr(1'b1, 1'b1, 3'd7);
        watch("R9", 11, 0, 0);
        wr(1'b1, 1'b0, 3'd2);
        watch("R9", 8, 4, 0);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_grow();
        wr(1'b1, 1'b1, 3'd2);
        watch("R9", 3, 0, 0);
        wr(1'b1, 1'b0, 3'd5);
        watch("R9", 17, 16, 0);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_enable_start();
        // R2: enabling write without the restart bit still starts from zero.
        wr(1'b1, 1'b0, 3'd1);
        watch("R2", 3 * T, T, T);
        wr(1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_start();
        t_codes();
        t_code0();
        t_disable();
        t_clear();
        t_noclear();
        t_shrink();
        t_grow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule